// File: doc/BRIEF.md
# Two-Column AES Round Datapath

This block computes half of one AES round for a 64-bit processor. Two 64-bit source operands together carry the full 128-bit cipher state. A two-bit operation code picks the direction (encrypt or decrypt) and the round kind (middle or final). Each operation returns the two low state columns of the transformed state as one 64-bit word. Software gets the other two columns by issuing the same operation again with the operands exchanged. Two operations therefore make up a full round. Round-key addition, operand storage and sequencing of the cipher across rounds are left to the surrounding core.

Internally the block has three parts. A fixed byte-routing network applies the forward or inverse row rotation across the operand pair. Eight byte lanes then compute the substitution, each lane sharing one field-inverse circuit between both directions. Two column mixers apply the forward or inverse column mix. One register stage holds the result. The delay from input to result is one clock in every case, whatever the data values are.

Top module: `aes_halfround_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 otherwise. The delay does not depend on the operand values or on `in_op`.
- R3: `in_op` = 2'b00 (encrypt, final round) returns columns 0 and 1 of the forward substitution applied to the forward row-rotated state. Row r moves left by r columns, so output byte (row r, column c) takes the input byte at row r, column (c+r) mod 4.
- R4: `in_op` = 2'b01 (encrypt, middle round) is R3 followed by the forward column mix of each of the two output columns, using the matrix rows {2,3,1,1} rotated per row.
- R5: `in_op` = 2'b10 (decrypt, final round) applies the inverse row rotation, where output (r,c) takes input (r,(c-r) mod 4), then the inverse substitution, with no column mix. Applying it to both halves of an R3 result restores the original state.
- R6: `in_op` = 2'b11 (decrypt, middle round) is R5 followed by the inverse column mix, using matrix rows {14,11,13,9} rotated per row.
- R7: The state is {`src_hi`, `src_lo`}. State byte i sits at bits 8i+7:8i, and column c is bytes 4c to 4c+3 with row 0 in the lowest byte. `result` carries column 0 in bits 31:0 and column 1 in bits 63:32.
- R8: With `src_lo` and `src_hi` exchanged, `result` equals columns 2 and 3 of the same transformed state.
- R9: In a cycle with `in_valid` low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request this cycle |
| in_op | input | 2 | Bit 1: decrypt; bit 0: middle round |
| src_lo | input | 64 | State columns 0 and 1 |
| src_hi | input | 64 | State columns 2 and 3 |
| out_valid | output | 1 | Result produced this cycle |
| result | output | 64 | Two transformed state columns |

## Verification
The properties assume that `rst_n` is released synchronously and that `in_op` and the operands are known whenever `in_valid` is high. The stimulus drives every input only at falling edges, so these assumptions always hold. Some properties also depend on fixed states whose outputs are known in closed form: an all-zero state, or a state of all 0x63 or all 0x52 bytes. The bench drives those states as directed cases. The random states come from a seeded generator and cover all four opcodes in turn. Each state is issued in both operand orders.

// File: rtl/aes_hr_pkg.sv
package aes_hr_pkg;

    typedef enum logic [1:0] {
        OP_ENC_FINAL = 2'b00,
        OP_ENC_MID   = 2'b01,
        OP_DEC_FINAL = 2'b10,
        OP_DEC_MID   = 2'b11
    } hr_op_e;

    localparam int HR_XLEN      = 64;
    localparam int STATE_BYTES  = 16;
    localparam int COL_BYTES    = 4;

    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] t;
        acc = 8'h00;
        t   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ t;
            t = gf_xtime(t);
        end
        return acc;
    endfunction

    // a^254 built as (a^(2^7-1))^2; maps zero to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        r = a;
        for (int i = 0; i < 6; i++) begin
            r = gf_mul(gf_mul(r, r), a);
        end
        return gf_mul(r, r);
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
        logic [15:0] dbl;
        dbl = {x, x} << n;
        return dbl[15:8];
    endfunction

    // column-mix coefficient for distance d = (k - r) mod 4
    function automatic logic [7:0] mix_coef(input logic inverse, input int d);
        logic [7:0] c;
        case (d)
            0:       c = inverse ? 8'h0e : 8'h02;
            1:       c = inverse ? 8'h0b : 8'h03;
            2:       c = inverse ? 8'h0d : 8'h01;
            default: c = inverse ? 8'h09 : 8'h01;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/aes_row_shift.sv
module aes_row_shift #(
    parameter int OUT_BYTES = 8,
    parameter int ST_BYTES  = 16
) (
    input  logic                    inverse,
    input  logic [ST_BYTES*8-1:0]   state_in,
    output logic [OUT_BYTES*8-1:0]  picked
);
    localparam int NCOL = ST_BYTES / 4;

    for (genvar j = 0; j < OUT_BYTES; j++) begin : g_lane
        localparam int COL = j / 4;
        localparam int ROW = j % 4;
        localparam int FWD = 4 * ((COL + ROW) % NCOL) + ROW;
        localparam int INV = 4 * ((COL - ROW + NCOL) % NCOL) + ROW;
        assign picked[8*j +: 8] = inverse ? state_in[8*INV +: 8]
                                          : state_in[8*FWD +: 8];
    end

endmodule

// File: rtl/aes_sbox_lane.sv
module aes_sbox_lane
    import aes_hr_pkg::*;
(
    input  logic       inverse,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [7:0] pre_aff;
    logic [7:0] field_inv;

    always_comb begin
        if (inverse)
            pre_aff = rotl8(din, 1) ^ rotl8(din, 3) ^ rotl8(din, 6) ^ 8'h05;
        else
            pre_aff = din;
        field_inv = gf_inv(pre_aff);
        if (inverse)
            dout = field_inv;
        else
            dout = field_inv ^ rotl8(field_inv, 1) ^ rotl8(field_inv, 2)
                 ^ rotl8(field_inv, 3) ^ rotl8(field_inv, 4) ^ 8'h63;
    end

endmodule

// File: rtl/aes_mixcol_unit.sv
module aes_mixcol_unit
    import aes_hr_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic            inverse,
    input  logic [NB*8-1:0] col_in,
    output logic [NB*8-1:0] col_out
);
    always_comb begin
        for (int r = 0; r < NB; r++) begin
            logic [7:0] acc;
            acc = 8'h00;
            for (int k = 0; k < NB; k++) begin
                acc = acc ^ gf_mul(col_in[8*k +: 8], mix_coef(inverse, (k - r + NB) % NB));
            end
            col_out[8*r +: 8] = acc;
        end
    end

endmodule

// File: rtl/aes_halfround_unit.sv
module aes_halfround_unit
    import aes_hr_pkg::*;
#(
    parameter int XLEN = HR_XLEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [XLEN-1:0] src_lo,
    input  logic [XLEN-1:0] src_hi,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);
    localparam int NBYTES = XLEN / 8;
    localparam int NCOLS  = NBYTES / COL_BYTES;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] data;
    } stage_t;

    stage_t stage_d, stage_q;

    logic            is_dec;
    logic            is_mid;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] subbed;
    logic [XLEN-1:0] mixed;

    assign is_dec = in_op[1];
    assign is_mid = in_op[0];

    aes_row_shift #(
        .OUT_BYTES (NBYTES),
        .ST_BYTES  (2 * NBYTES)
    ) u_shift (
        .inverse  (is_dec),
        .state_in ({src_hi, src_lo}),
        .picked   (shifted)
    );

    for (genvar b = 0; b < NBYTES; b++) begin : g_sbox
        aes_sbox_lane u_lane (
            .inverse (is_dec),
            .din     (shifted[8*b +: 8]),
            .dout    (subbed[8*b +: 8])
        );
    end

    for (genvar c = 0; c < NCOLS; c++) begin : g_mix
        aes_mixcol_unit #(.NB(COL_BYTES)) u_mix (
            .inverse (is_dec),
            .col_in  (subbed[32*c +: 32]),
            .col_out (mixed[32*c +: 32])
        );
    end

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.data = is_mid ? mixed : subbed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign result    = stage_q.data;

endmodule

// File: rtl/aes_halfround_chk.sv
module aes_halfround_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  in_op,
    input logic [63:0] src_lo,
    input logic [63:0] src_hi,
    input logic        out_valid,
    input logic [63:0] result
);
    logic zero_state;
    assign zero_state = (src_lo == 64'h0) && (src_hi == 64'h0);

    p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_zero_final_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b00 && zero_state) |=> result == 64'h6363636363636363);

    p_zero_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b01 && zero_state) |=> result == 64'h6363636363636363);

    p_dec_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b10 && src_lo == {8{8'h63}} && src_hi == {8{8'h63}})
        |=> result == 64'h0);

    p_dec_mid_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b11 && zero_state) |=> result == {8{8'h52}});

endmodule

bind aes_halfround_unit aes_halfround_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .src_lo    (src_lo),
    .src_hi    (src_hi),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_aes_halfround_unit.sv
module tb_aes_halfround_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [63:0] src_lo = '0;
    logic [63:0] src_hi = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] fsb [256];
    logic [7:0] isb [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_halfround_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .src_lo(src_lo), .src_hi(src_hi), .out_valid(out_valid), .result(result)
    );

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0, x = a, y = b;
        while (y != 0) begin
            if (y[0]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic void build_tables();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0, s;
            for (int y = 1; y < 256; y++)
                if (x != 0 && fmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
            fsb[x] = s;
            isb[s] = 8'(x);
        end
    endfunction

    // full-round reference on a 128-bit state: op[1]=decrypt, op[0]=middle
    function automatic logic [127:0] ref_round(input logic [1:0] op, input logic [127:0] s);
        logic [7:0] t [16];
        logic [127:0] o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                int src = op[1] ? 4*((c - r + 4) % 4) + r : 4*((c + r) % 4) + r;
                t[4*c+r] = op[1] ? isb[s[8*src +: 8]] : fsb[s[8*src +: 8]];
            end
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                logic [7:0] v = 0;
                if (!op[0]) v = t[4*c+r];
                else if (!op[1])
                    v = fmul(8'h02, t[4*c+r]) ^ fmul(8'h03, t[4*c+(r+1)%4])
                      ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
                else
                    v = fmul(8'h0e, t[4*c+r]) ^ fmul(8'h0b, t[4*c+(r+1)%4])
                      ^ fmul(8'h0d, t[4*c+(r+2)%4]) ^ fmul(8'h09, t[4*c+(r+3)%4]);
                o[8*(4*c+r) +: 8] = v;
            end
        return o;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [63:0] lo, input logic [63:0] hi,
                          output logic [63:0] res, output logic vld);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; src_lo = lo; src_hi = hi;
        @(negedge clk);
        res = result; vld = out_valid;
        in_valid = 1'b0;
    endtask

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] res, res2, e_lo, e_hi;
        logic vld;
        logic [127:0] st, ex;
        void'($urandom(32'h5eed_a35));
        build_tables();

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid", {63'h0, out_valid}, 64'h0);
        check("R1 result", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {63'h0, out_valid} | result, 64'h0);

        // R2: valid one cycle later, gone the cycle after
        run_op(2'b01, 64'hffff_0000_1234_5678, 64'h0, res, vld);
        check("R2 latency", {63'h0, vld}, 64'h1);
        @(negedge clk);
        check("R2 idle", {63'h0, out_valid}, 64'h0);

        // R4/R3/R7: known first-round state (byte 0 in low bits)
        run_op(2'b01, 64'h2be2f4a0_bee33d19, 64'h0848f8e9_2a8dc69a, res, vld);
        check("R4 R7 known lo", res, 64'h9a19cbe0_e5816604);
        run_op(2'b01, 64'h0848f8e9_2a8dc69a, 64'h2be2f4a0_bee33d19, res, vld);
        check("R4 R8 known hi", res, 64'h4c260628_7ad3f848);
        run_op(2'b00, 64'h2be2f4a0_bee33d19, 64'h0848f8e9_2a8dc69a, e_lo, vld);
        check("R3 R7 known lo", e_lo, 64'hae52b4e0_305dbfd4);
        run_op(2'b00, 64'h0848f8e9_2a8dc69a, 64'h2be2f4a0_bee33d19, e_hi, vld);
        check("R3 R8 known hi", e_hi, 64'he598271e_f11141b8);

        // R5: decrypt-final undoes encrypt-final
        run_op(2'b10, e_lo, e_hi, res, vld);
        check("R5 roundtrip lo", res, 64'h2be2f4a0_bee33d19);
        run_op(2'b10, e_hi, e_lo, res, vld);
        check("R5 roundtrip hi", res, 64'h0848f8e9_2a8dc69a);

        // corner states
        run_op(2'b00, 64'h0, 64'h0, res, vld);
        check("R3 zero", res, {8{8'h63}});
        run_op(2'b11, 64'h0, 64'h0, res, vld);
        check("R6 zero", res, {8{8'h52}});
        run_op(2'b10, {8{8'h63}}, {8{8'h63}}, res, vld);
        check("R5 const", res, 64'h0);

        // random states, all opcodes, both operand orders
        for (int i = 0; i < 400; i++) begin
            logic [1:0] op = 2'(i % 4);
            st = {$urandom, $urandom, $urandom, $urandom};
            ex = ref_round(op, st);
            run_op(op, st[63:0], st[127:64], res, vld);
            check(op_tag(op), res, ex[63:0]);
            check("R2 valid", {63'h0, vld}, 64'h1);
            run_op(op, st[127:64], st[63:0], res2, vld);
            check("R8 swapped", res2, ex[127:64]);
        end

        // R9: result held while idle with changing inputs
        run_op(2'b11, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, res, vld);
        for (int k = 0; k < 4; k++) begin
            src_lo = {$urandom, $urandom}; src_hi = {$urandom, $urandom};
            in_op = 2'($urandom);
            @(negedge clk);
            check("R9 hold", result, res);
            check("R2 no valid", {63'h0, out_valid}, 64'h0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule